// File: doc/BRIEF.md
# Two-Stage Significand Alignment Shifter with Parallel Sticky

This block aligns the smaller operand of a floating-point adder. It takes a 53-bit significand whose leading one is explicit and a 6-bit right-shift distance, and it returns the shifted significand together with guard, round and sticky bits. The block has one register stage. A request is accepted in a cycle where `inValid` is high, and the result appears on the outputs on the next rising edge.

The shift runs in two cascaded stages. The low three bits of the distance drive a fine stage, built from multiplexer layers that move the data by 1, 2 and 4 places. The upper three bits drive a coarse stage that moves the data in steps of 8. The sticky bit is not taken from the finished shifter output. Each stage has its own mask generator, which marks the bit positions that drop off the bottom for that stage's part of the distance. The masked bits are OR-reduced side by side with the shifting, so the sticky logic adds little depth after the coarse stage.

A precision select handles single-precision operands. In that mode the 24-bit significand sits in the low bits of the input. The block moves it to the top of the 53-bit path and fills the bits below it with zeros.

Top module: `align_shifter`

## Requirements
- R1: After reset `outValid`, `alignedSig`, `guardBit`, `roundBit` and `stickyBit` are all 0. `outValid` is 1 in the cycle after a cycle with `inValid` high, and 0 after a cycle with `inValid` low.
- R2: Let E be the 55-bit value {S, 2'b00}, where S is the effective significand (see R5), and let W = E >> shiftAmt. For shiftAmt below 55, `alignedSig` equals W[54:2], `guardBit` equals W[1] and `roundBit` equals W[0].
- R3: `stickyBit` is the OR of every bit of E at a position below shiftAmt. It is therefore 1 exactly when a nonzero bit falls below the round position.
- R4: For shiftAmt of 55 or more, `alignedSig` is 0, `guardBit` and `roundBit` are 0, and `stickyBit` equals the OR of all bits of S.
- R5: With `isSingle` = 0, S is `sigIn`. With `isSingle` = 1, S is {sigIn[23:0], 29'b0}, and sigIn[52:24] has no effect on any output.
- R6: With shiftAmt = 0, `alignedSig` equals S, and guard, round and sticky are all 0.
- R7: While `inValid` is low, every result output keeps its value, whatever happens on `sigIn`, `shiftAmt` and `isSingle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe; inputs are captured when high |
| sigIn | input | 53 | Significand with explicit leading one |
| shiftAmt | input | 6 | Right-shift distance, 0 to 63 |
| isSingle | input | 1 | 1 = single precision in sigIn[23:0] |
| outValid | output | 1 | Result is from the previous cycle's request |
| alignedSig | output | 53 | Shifted significand |
| guardBit | output | 1 | First bit below the retained significand |
| roundBit | output | 1 | Second bit below the retained significand |
| stickyBit | output | 1 | OR of all bits below the round position |

## Verification
The assertions compare each registered result against the inputs sampled one edge earlier. They therefore assume that every input is at a known value at any edge where `inValid` is high, and that `shiftAmt` may take any of its 64 codes. The bench keeps all inputs driven from time zero and changes them only on falling edges. It walks every shift distance from 0 to 63 for several significand patterns in both precisions, so the properties for distance 0 and for distances beyond the path width are both exercised.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int SIG_W    = 53;
  localparam int SHIFT_W  = 6;
  localparam int FINE_W   = 3;
  localparam int SINGLE_W = 24;

  typedef struct packed {
    logic             capture;
    logic             single;
    logic [FINE_W-1:0] fineAmt;
    logic [SHIFT_W-FINE_W-1:0] coarseAmt;
  } alignCtrl_t;
endpackage

// File: rtl/align_ctrl.sv
module align_ctrl
  import align_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               isSingle,
  output alignCtrl_t         ctrl,
  output logic               outValid
);
  // split the distance into fine and coarse parts
  always_comb begin
    ctrl.capture   = inValid;
    ctrl.single    = isSingle;
    ctrl.fineAmt   = shiftAmt[FINE_W-1:0];
    ctrl.coarseAmt = shiftAmt[SHIFT_W-1:FINE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid)));
endmodule

// File: rtl/align_datapath.sv
module align_datapath
  import align_pkg::*;
#(
  parameter int SIG_BITS   = SIG_W,
  parameter int SHIFT_BITS = SHIFT_W,
  parameter int FINE_BITS  = FINE_W,
  parameter int SGL_BITS   = SINGLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  alignCtrl_t          ctrl,
  input  logic [SIG_BITS-1:0] sigIn,
  output logic [SIG_BITS-1:0] alignedSig,
  output logic                guardBit,
  output logic                roundBit,
  output logic                stickyBit
);
  localparam int EXT_W       = SIG_BITS + 2;
  localparam int PAD_W       = SIG_BITS - SGL_BITS;
  localparam int COARSE_BITS = SHIFT_BITS - FINE_BITS;
  localparam int STEP        = 1 << FINE_BITS;

  logic [SIG_BITS-1:0] effSig;
  logic [EXT_W-1:0]    extIn;
  logic [EXT_W-1:0]    fineLayer   [0:FINE_BITS];
  logic [EXT_W-1:0]    coarseLayer [0:COARSE_BITS];
  logic [EXT_W-1:0]    maskFine;
  logic [EXT_W-1:0]    maskCoarse;
  logic                stickyFine;
  logic                stickyCoarse;

  // precision placement: single operands go to the top of the path
  assign effSig = ctrl.single ? {sigIn[SGL_BITS-1:0], {PAD_W{1'b0}}} : sigIn;
  assign extIn  = {effSig, 2'b00};

  // fine stage: layers weighted 1, 2, 4
  assign fineLayer[0] = extIn;
  for (genvar k = 0; k < FINE_BITS; k++) begin : gFine
    assign fineLayer[k+1] = ctrl.fineAmt[k] ? (fineLayer[k] >> (1 << k)) : fineLayer[k];
  end

  // coarse stage: layers weighted 8, 16, 32
  assign coarseLayer[0] = fineLayer[FINE_BITS];
  for (genvar k = 0; k < COARSE_BITS; k++) begin : gCoarse
    assign coarseLayer[k+1] = ctrl.coarseAmt[k] ? (coarseLayer[k] >> (STEP << k)) : coarseLayer[k];
  end

  // mask generators, one per stage
  for (genvar i = 0; i < EXT_W; i++) begin : gMask
    assign maskFine[i]   = (int'(ctrl.fineAmt) > i);
    assign maskCoarse[i] = (int'(ctrl.coarseAmt) * STEP > i);
  end

  assign stickyFine   = |(extIn & maskFine);
  assign stickyCoarse = |(fineLayer[FINE_BITS] & maskCoarse);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignedSig <= '0;
      guardBit   <= 1'b0;
      roundBit   <= 1'b0;
      stickyBit  <= 1'b0;
    end else if (ctrl.capture) begin
      alignedSig <= coarseLayer[COARSE_BITS][EXT_W-1:2];
      guardBit   <= coarseLayer[COARSE_BITS][1];
      roundBit   <= coarseLayer[COARSE_BITS][0];
      stickyBit  <= stickyFine | stickyCoarse;
    end
  end

  // large distances flush everything into sticky
  assert_flush_large_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && ({ctrl.coarseAmt, ctrl.fineAmt} >= SHIFT_BITS'(EXT_W)))
    |=> (alignedSig == '0 && !guardBit && !roundBit && stickyBit == $past(|effSig)));

  // zero distance is a pass-through
  assert_zero_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && ctrl.coarseAmt == '0 && ctrl.fineAmt == '0)
    |=> (alignedSig == $past(effSig) && !guardBit && !roundBit && !stickyBit));

  // idle cycles leave the result untouched
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(alignedSig) && $stable(guardBit) &&
                       $stable(roundBit) && $stable(stickyBit)));

  // a sticky bit needs a nonzero operand
  assert_sticky_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && effSig == '0) |=> (!stickyBit && alignedSig == '0));

  // single precision leaves the low pad bits clear
  assert_single_pad_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && ctrl.single && ctrl.coarseAmt == '0 && ctrl.fineAmt == '0)
    |=> (alignedSig[PAD_W-1:0] == '0));
endmodule

// File: rtl/align_shifter.sv
module align_shifter
  import align_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SIG_W-1:0]   sigIn,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               isSingle,
  output logic               outValid,
  output logic [SIG_W-1:0]   alignedSig,
  output logic               guardBit,
  output logic               roundBit,
  output logic               stickyBit
);
  alignCtrl_t ctrl;

  align_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .shiftAmt(shiftAmt),
    .isSingle(isSingle), .ctrl(ctrl), .outValid(outValid)
  );

  align_datapath uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sigIn(sigIn),
    .alignedSig(alignedSig), .guardBit(guardBit),
    .roundBit(roundBit), .stickyBit(stickyBit)
  );
endmodule

// File: tb/sim_align_shifter.sv
`timescale 1ns/1ps
module sim_align_shifter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [52:0] sigIn = '0;
  logic [5:0]  shiftAmt = '0;
  logic        isSingle = 1'b0;
  logic        outValid;
  logic [52:0] alignedSig;
  logic        guardBit, roundBit, stickyBit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  align_shifter u0 (.*);

  localparam int NV = 8;
  localparam logic [52:0] VSIG [NV] = '{
    53'h10_0000_0000_0000, 53'h1F_FFFF_FFFF_FFFF, 53'h10_0000_0000_0001,
    53'h1A_5A5A_5A5A_5A5A, 53'h15_5555_5555_5555, 53'h1F_FFFF_FF80_0000,
    53'h00_0000_0000_0000, 53'h1F_0000_00C0_0001};
  localparam bit VSGL [NV] = '{0, 0, 0, 0, 1, 1, 0, 1};

  function automatic logic [55:0] model(logic [52:0] s, logic [5:0] sh, bit sgl);
    logic [52:0]  e;
    logic [118:0] w;
    e = sgl ? {s[23:0], 29'b0} : s;
    w = {e, 2'b00, 64'b0} >> sh;
    return {w[118:66], w[65], w[64], |w[63:0]};
  endfunction

  task automatic check(string req, logic [55:0] act, logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [52:0] s, logic [5:0] sh, bit sgl);
    @(negedge clk);
    sigIn = s; shiftAmt = sh; isSingle = sgl; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [55:0] outs();
    return {alignedSig, guardBit, roundBit, stickyBit};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [55:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset", {outs(), 55'b0} >> 55 | {55'b0, outValid}, 56'h0);
    check("R1 reset outputs", outs(), 56'h0);
    rstN = 1'b1;

    // table walk: every vector at every distance (R2 R3 R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      for (int sh = 0; sh < 64; sh++) begin
        apply(VSIG[v], 6'(sh), VSGL[v]);
        check(sh == 0 ? "R6 zero" : (sh >= 55 ? "R4 flush" : "R2/R3 shift"),
              outs(), model(VSIG[v], 6'(sh), VSGL[v]));
      end
    end

    // R1 valid pulse timing
    @(negedge clk);
    check("R1 idle valid low", {55'b0, outValid}, 56'h0);
    apply(53'h10_0000_0000_0000, 6'd3, 1'b0);
    check("R1 valid high", {55'b0, outValid}, 56'h1);

    // R3 single lost bit below round
    apply(53'h10_0000_0000_0001, 6'd3, 1'b0);
    check("R3 sticky one bit", {55'b0, stickyBit}, 56'h1);
    apply(53'h10_0000_0000_0001, 6'd2, 1'b0);
    check("R3 no sticky at round", {53'b0, guardBit, roundBit, stickyBit}, 56'h2);

    // R4 flush sticky
    apply(53'h00_0000_0000_0004, 6'd63, 1'b0);
    check("R4 flush", outs(), 56'h1);

    // R5 upper bits ignored in single mode
    apply(53'h1F_FFFF_FF00_0001, 6'd0, 1'b1);
    check("R5 single ignore upper", outs(), {24'h000001, 29'b0, 3'b0});
    apply(53'h00_0000_0000_0001, 6'd0, 1'b1);
    check("R5 single ignore upper b", outs(), {24'h000001, 29'b0, 3'b0});

    // R7 hold while idle
    apply(53'h1A_5A5A_5A5A_5A5A, 6'd13, 1'b0);
    held = outs();
    @(negedge clk);
    sigIn = 53'h0; shiftAmt = 6'd40; isSingle = 1'b1;
    @(negedge clk);
    check("R7 hold", outs(), held);
    check("R7 hold matches model", held, model(53'h1A_5A5A_5A5A_5A5A, 6'd13, 1'b0));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule